// File: doc/BRIEF.md
# E1 CRC-4 Block Error and Far-End Error Monitor

This block watches an E1 receive bit stream after a separate aligner has found the CRC-4 multiframe. Each cycle with `bit_valid` high brings one received bit, along with its position inside the frame and the frame's number inside the 16-frame multiframe. The block divides each half-multiframe of eight frames by the CRC-4 generator. It then checks the remainder against the check bits that arrive in the half-multiframe that follows. Each mismatch is counted as a local block error.

The same stream carries two far-end error indicators per multiframe. The block counts every indicator that reports an error. Each of the two counters is a wrapping counter with a sticky overflow flag and a maskable interrupt line. The host reads the counts and acknowledges overflows through plain ports.

Top module: `crc4_err_mon`

## Requirements
- R1: Block errors are counted only while `mf_lock` is high. A half-multiframe is checked only if it and the one before it were both received in full, from their first bit, with lock held throughout. As a result, the first half-multiframe after lock is gained is never checked.
- R2: The remainder is taken with generator x^4 + x + 1 over all bits of one half-multiframe, with the check-bit positions read as zero. Half-multiframe one is frames 0–7 and half-multiframe two is frames 8–15. A check-bit position is bit position 0 of an even-numbered frame. The check bit in the lowest even frame of a half-multiframe is the remainder's x^3 coefficient, and the others follow in frame order down to x^0. Each remainder is compared with the four check bits carried by the next half-multiframe.
- R3: Each mismatch adds exactly one to `bec_count`. The new value is visible on the cycle after the last bit of the half-multiframe that carried the mismatching check bits. Without a mismatch the count holds.
- R4: `bec_count` wraps from all-ones to zero. The wrap sets `bec_ovf`, which stays set until `bec_ovf_clr` is pulsed. If a wrap and a clear fall in the same cycle, the set wins.
- R5: `bec_irq` is high exactly when `bec_ovf` is set and `bec_mask` is low. `rebe_irq` follows `rebe_ovf` and `rebe_mask` in the same way.
- R6: While locked, bit position 0 of frames 13 and 15 carries a far-end error indicator, and a value of 0 means an error. Each such 0 adds one to `rebe_count`. A value of 1 leaves the count unchanged.
- R7: `rebe_count` wraps from all-ones to zero and sets `rebe_ovf`, which is sticky and is cleared by `rebe_ovf_clr`. A set wins over a clear in the same cycle.
- R8: Cycles with `bit_valid` low change no count and no flag, whatever the other inputs carry.
- R9: After reset, both counts, both overflow flags and both interrupts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received bit |
| bit_pos | input | $clog2(BITS_PER_FRAME) | Bit position inside the frame, 0 = first bit of the frame |
| frame_num | input | 4 | Frame number inside the multiframe, 0–15 |
| mf_lock | input | 1 | CRC-4 multiframe alignment held |
| bec_mask | input | 1 | Masks the block error overflow interrupt |
| rebe_mask | input | 1 | Masks the far-end error overflow interrupt |
| bec_ovf_clr | input | 1 | Clears the block error overflow flag |
| rebe_ovf_clr | input | 1 | Clears the far-end error overflow flag |
| bec_count | output | CNT_W | Local block error count |
| rebe_count | output | CNT_W | Far-end reported error count |
| bec_ovf | output | 1 | Sticky block error counter overflow |
| rebe_ovf | output | 1 | Sticky far-end counter overflow |
| bec_irq | output | 1 | Block error overflow interrupt |
| rebe_irq | output | 1 | Far-end overflow interrupt |

## Verification
The bench builds whole multiframes itself. The payload is all zeros, all ones, alternating, or pseudo-random, and its remainder is found by plain long division. Each check nibble is correct or corrupted in one, two or all four bits, so an error in bit order or in check-bit zeroing shows up as a wrong count. Idle cycles are inserted that carry tempting frame and bit positions with zero data, which separates valid gating from position decoding. The bench also drops and regains lock to show that the first half-multiframe after lock is gained goes unchecked, and it drives both counters through a wrap to exercise the masks and the clears.

// File: rtl/crc4_mon_pkg.sv
package crc4_mon_pkg;
  localparam int FRAMES_PER_MF  = 16;
  localparam int FRAMES_PER_SMF = 8;
  localparam int CRC_W          = 4;
  localparam logic [CRC_W-1:0] CRC_POLY_LOW = 4'b0011; // x^4 + x + 1 without x^4
  localparam logic [3:0] FE_FRAME_A = 4'd13;
  localparam logic [3:0] FE_FRAME_B = 4'd15;

  typedef logic [CRC_W-1:0] crc_t;

  // One serial step of the CRC-4 division (remainder of M(x)*x^4 mod G(x)).
  function automatic crc_t crc4_step(input crc_t cur, input logic din);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY_LOW);
  endfunction
endpackage

// File: rtl/crc4_smf_engine.sv
module crc4_smf_engine
  import crc4_mon_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  localparam int POS_W = $clog2(BITS_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             rx_bit,
  input  logic [POS_W-1:0] bit_pos,
  input  logic [3:0]       frame_num,
  input  logic             mf_lock,
  output logic             smf_end,
  output logic             blk_err
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BITS_PER_FRAME - 1);

  logic smf_start, cbit_pos, din;
  crc_t crc_run, crc_nxt, crc_prev, rx_chk;
  logic cur_full, prev_ok;

  assign smf_start = bit_valid && (frame_num[2:0] == 3'd0) && (bit_pos == '0);
  assign smf_end   = bit_valid && (frame_num[2:0] == 3'd7) && (bit_pos == LAST_POS);
  assign cbit_pos  = (bit_pos == '0) && !frame_num[0];
  assign din       = cbit_pos ? 1'b0 : rx_bit;
  assign crc_nxt   = crc4_step(smf_start ? crc_t'(0) : crc_run, din);

  assign blk_err = smf_end && mf_lock && cur_full && prev_ok && (rx_chk != crc_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_run  <= '0;
      crc_prev <= '0;
      rx_chk   <= '0;
      cur_full <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (!mf_lock) begin
      crc_run  <= '0;
      cur_full <= 1'b0;
      prev_ok  <= 1'b0;
    end else if (bit_valid) begin
      crc_run <= crc_nxt;
      if (cbit_pos) rx_chk[2'd3 - frame_num[2:1]] <= rx_bit;
      if (smf_start) cur_full <= 1'b1;
      if (smf_end) begin
        crc_prev <= crc_nxt;
        prev_ok  <= cur_full;
        cur_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc4_fe_extract.sv
module crc4_fe_extract
  import crc4_mon_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  localparam int POS_W = $clog2(BITS_PER_FRAME)
) (
  input  logic             bit_valid,
  input  logic             rx_bit,
  input  logic [POS_W-1:0] bit_pos,
  input  logic [3:0]       frame_num,
  input  logic             mf_lock,
  output logic             fe_hit
);
  logic in_slot;
  assign in_slot = (bit_pos == '0) && ((frame_num == FE_FRAME_A) || (frame_num == FE_FRAME_B));
  assign fe_hit  = bit_valid && mf_lock && in_slot && !rx_bit;
endmodule

// File: rtl/crc4_wrap_counter.sv
module crc4_wrap_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic wrap;
  assign wrap = inc && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (inc) count <= count + 1'b1;
      if (wrap) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/crc4_err_mon.sv
module crc4_err_mon #(
  parameter int BITS_PER_FRAME = 256,
  parameter int CNT_W = 10,
  localparam int POS_W = $clog2(BITS_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             rx_bit,
  input  logic [POS_W-1:0] bit_pos,
  input  logic [3:0]       frame_num,
  input  logic             mf_lock,
  input  logic             bec_mask,
  input  logic             rebe_mask,
  input  logic             bec_ovf_clr,
  input  logic             rebe_ovf_clr,
  output logic [CNT_W-1:0] bec_count,
  output logic [CNT_W-1:0] rebe_count,
  output logic             bec_ovf,
  output logic             rebe_ovf,
  output logic             bec_irq,
  output logic             rebe_irq
);
  logic smf_end, blk_err, rebe_hit;

  crc4_smf_engine #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_engine (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .bit_pos(bit_pos), .frame_num(frame_num), .mf_lock(mf_lock),
    .smf_end(smf_end), .blk_err(blk_err)
  );

  crc4_fe_extract #(.BITS_PER_FRAME(BITS_PER_FRAME)) u_fe (
    .bit_valid(bit_valid), .rx_bit(rx_bit), .bit_pos(bit_pos),
    .frame_num(frame_num), .mf_lock(mf_lock), .fe_hit(rebe_hit)
  );

  crc4_wrap_counter #(.CNT_W(CNT_W)) u_bec_cnt (
    .clk(clk), .rst_n(rst_n), .inc(blk_err), .ovf_clr(bec_ovf_clr),
    .count(bec_count), .ovf(bec_ovf)
  );

  crc4_wrap_counter #(.CNT_W(CNT_W)) u_rebe_cnt (
    .clk(clk), .rst_n(rst_n), .inc(rebe_hit), .ovf_clr(rebe_ovf_clr),
    .count(rebe_count), .ovf(rebe_ovf)
  );

  assign bec_irq  = bec_ovf && !bec_mask;
  assign rebe_irq = rebe_ovf && !rebe_mask;
endmodule

// File: rtl/crc4_err_mon_chk.sv
module crc4_err_mon_chk #(
  parameter int BITS_PER_FRAME = 256,
  parameter int CNT_W = 10,
  localparam int POS_W = $clog2(BITS_PER_FRAME)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             rx_bit,
  input logic [POS_W-1:0] bit_pos,
  input logic [3:0]       frame_num,
  input logic             mf_lock,
  input logic             bec_mask,
  input logic             bec_ovf_clr,
  input logic             smf_end,
  input logic             blk_err,
  input logic             rebe_hit,
  input logic [CNT_W-1:0] bec_count,
  input logic [CNT_W-1:0] rebe_count,
  input logic             bec_ovf,
  input logic             bec_irq
);
  AST_NO_CHECK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lock |-> !blk_err); // R1
  AST_ERR_AT_SMF_END: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |-> smf_end); // R2
  AST_BEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |=> bec_count == CNT_W'($past(bec_count) + 1'b1)); // R3
  AST_BEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_err |=> $stable(bec_count)); // R3
  AST_BEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_err && bec_count == {CNT_W{1'b1}}) |=> (bec_ovf && bec_count == '0)); // R4
  AST_BEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bec_ovf_clr && !blk_err) |=> !bec_ovf); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bec_mask || !bec_ovf) |-> !bec_irq); // R5
  AST_FE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rebe_hit |-> (bit_pos == '0 && !rx_bit && (frame_num == 4'd13 || frame_num == 4'd15))); // R6
  AST_REBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rebe_hit |=> $stable(rebe_count)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> (!blk_err && !rebe_hit)); // R8
endmodule

bind crc4_err_mon crc4_err_mon_chk #(.BITS_PER_FRAME(BITS_PER_FRAME), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
  .bit_pos(bit_pos), .frame_num(frame_num), .mf_lock(mf_lock),
  .bec_mask(bec_mask), .bec_ovf_clr(bec_ovf_clr), .smf_end(smf_end),
  .blk_err(blk_err), .rebe_hit(rebe_hit), .bec_count(bec_count),
  .rebe_count(rebe_count), .bec_ovf(bec_ovf), .bec_irq(bec_irq)
);

// File: tb/crc4_err_mon_bench.sv
`timescale 1ns/1ps
module crc4_err_mon_bench;
  localparam int BPF  = 16;
  localparam int CW   = 4;
  localparam int PW   = $clog2(BPF);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, rx_bit = 1'b0, mf_lock = 1'b0;
  logic [PW-1:0] bit_pos = '0;
  logic [3:0] frame_num = '0;
  logic bec_mask = 1'b0, rebe_mask = 1'b0, bec_ovf_clr = 1'b0, rebe_ovf_clr = 1'b0;
  logic [CW-1:0] bec_count, rebe_count;
  logic bec_ovf, rebe_ovf, bec_irq, rebe_irq;

  int nchk = 0, nerr = 0;
  int exp_bec = 0, exp_rebe = 0;
  bit exp_bovf = 0, exp_rovf = 0;
  bit prev_valid = 0;
  logic [3:0] prev_crc = '0;
  logic [15:0] prbs = 16'hACE1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  crc4_err_mon #(.BITS_PER_FRAME(BPF), .CNT_W(CW)) u_crc4_err_mon (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .bit_pos(bit_pos), .frame_num(frame_num), .mf_lock(mf_lock),
    .bec_mask(bec_mask), .rebe_mask(rebe_mask), .bec_ovf_clr(bec_ovf_clr),
    .rebe_ovf_clr(rebe_ovf_clr), .bec_count(bec_count), .rebe_count(rebe_count),
    .bec_ovf(bec_ovf), .rebe_ovf(rebe_ovf), .bec_irq(bec_irq), .rebe_irq(rebe_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    bit_valid = 1'b0;
    rx_bit    = 1'b0;          // tempting: zero on a far-end slot
    frame_num = 4'd13;
    bit_pos   = '0;
  endtask

  task automatic send_bit(input logic b, input int fr, input int pos, input bit gap);
    if (gap) idle_cycle();
    @(negedge clk);
    bit_valid = 1'b1;
    rx_bit    = b;
    frame_num = 4'(fr);
    bit_pos   = PW'(pos);
  endtask

  function automatic logic payload(input int mode, input int pos);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: begin
        prbs = {prbs[14:0], prbs[15] ^ prbs[13] ^ prbs[12] ^ prbs[10]};
        return prbs[0];
      end
      default: return 1'(pos & 1);
    endcase
  endfunction

  function automatic void bump(inout int cnt, inout bit ovf);
    if (cnt == CMAX) begin cnt = 0; ovf = 1; end
    else cnt++;
  endfunction

  // Send one half-multiframe; corrupt flips check bits (bit 3 = first check bit).
  task automatic send_smf(input int half, input logic [3:0] corrupt, input logic e13,
                          input logic e15, input int mode, input bit gap);
    logic [4:0] r;
    bit pv;
    pv = prev_valid && mf_lock;
    r = '0;
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < BPF; p++) begin
        int fr;
        logic b, d;
        fr = half * 8 + f;
        if (p == 0) begin
          if (fr % 2 == 0) b = prev_crc[3 - f/2] ^ corrupt[3 - f/2];
          else if (fr == 13) b = e13;
          else if (fr == 15) b = e15;
          else b = 1'b1;
        end else b = payload(mode, p);
        d = (p == 0 && fr % 2 == 0) ? 1'b0 : b;
        r = {r[3:0], d};
        if (r[4]) r = r ^ 5'b10011;
        if (p == 0 && mf_lock && (fr == 13 || fr == 15) && !b) bump(exp_rebe, exp_rovf);
        send_bit(b, fr, p, gap && (p % 3 == 1));
      end
    end
    for (int k = 0; k < 4; k++) begin
      r = {r[3:0], 1'b0};
      if (r[4]) r = r ^ 5'b10011;
    end
    if (pv && corrupt != 4'd0) bump(exp_bec, exp_bovf);
    prev_crc   = r[3:0];
    prev_valid = mf_lock;
  endtask

  task automatic send_mf(input logic [3:0] c1, input logic [3:0] c2, input logic e13,
                         input logic e15, input int mode, input bit gap);
    send_smf(0, c1, 1'b1, 1'b1, mode, gap);
    send_smf(1, c2, e13, e15, mode, gap);
    idle_cycle();
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R3 bec_count"}, int'(bec_count), exp_bec);
    chk({tag, " R6 rebe_count"}, int'(rebe_count), exp_rebe);
    chk({tag, " R4 bec_ovf"}, int'(bec_ovf), int'(exp_bovf));
    chk({tag, " R7 rebe_ovf"}, int'(rebe_ovf), int'(exp_rovf));
    chk({tag, " R5 bec_irq"}, int'(bec_irq), int'(exp_bovf && !bec_mask));
    chk({tag, " R5 rebe_irq"}, int'(rebe_irq), int'(exp_rovf && !rebe_mask));
  endtask

  initial begin
    #750000;
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("reset R9");

    // R1: first half after lock gained is not checked even with bad check bits
    mf_lock = 1'b1;
    send_mf(4'hF, 4'h0, 1'b1, 1'b1, 0, 0);
    check_all("first-after-lock R1");

    // R2/R6: single bit corruptions at each end of the nibble, varied payloads
    send_mf(4'h0, 4'b0001, 1'b0, 1'b1, 2, 0);
    check_all("prbs c4 R2");
    send_mf(4'b1000, 4'h0, 1'b1, 1'b0, 1, 0);
    check_all("ones c1 R2");
    send_mf(4'h0, 4'h0, 1'b0, 1'b0, 3, 0);
    check_all("alt clean R2");

    // R8: idle cycles with tempting values between bits
    send_mf(4'b0110, 4'hF, 1'b1, 1'b1, 2, 1);
    check_all("gaps R8");
    send_mf(4'h0, 4'h0, 1'b0, 1'b1, 2, 1);
    check_all("gaps clean R8");

    // R1: unlocked stretch counts nothing, relock skips the first half
    mf_lock = 1'b0;
    send_mf(4'hF, 4'hF, 1'b0, 1'b0, 2, 0);
    check_all("unlocked R1");
    mf_lock = 1'b1;
    send_mf(4'hF, 4'h0, 1'b0, 1'b1, 2, 0);
    check_all("relock R1");
    send_mf(4'b0100, 4'b0010, 1'b1, 1'b1, 0, 0);
    check_all("after relock R2");

    // R4/R5: drive block error counter through a wrap
    while (!exp_bovf) send_mf(4'hF, 4'hF, 1'b1, 1'b1, 2, 0);
    check_all("bec wrap R4");
    @(negedge clk); bec_mask = 1'b1;
    @(negedge clk);
    check_all("bec masked R5");
    bec_ovf_clr = 1'b1; @(negedge clk); bec_ovf_clr = 1'b0; exp_bovf = 0;
    @(negedge clk);
    check_all("bec cleared R4");
    bec_mask = 1'b0;

    // R7: far-end counter through a wrap
    while (!exp_rovf) send_mf(4'h0, 4'h0, 1'b0, 1'b0, 3, 0);
    check_all("rebe wrap R7");
    @(negedge clk); rebe_mask = 1'b1;
    @(negedge clk);
    check_all("rebe masked R5");
    rebe_ovf_clr = 1'b1; @(negedge clk); rebe_ovf_clr = 1'b0; exp_rovf = 0;
    @(negedge clk);
    check_all("rebe cleared R7");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule